// File: doc/BRIEF.md
# Accumulator ALU with Binary and Packed-Decimal Arithmetic

This block is the arithmetic and logic stage of an 8-bit accumulator processor. Each cycle it takes a 4-bit operation code, the accumulator byte, an operand byte and the current status flag byte. One clock edge later it presents the result byte and the updated flag byte on registered outputs. The register file, the instruction sequencer and memory writeback sit outside the block. They pick the operand source, decide whether the result is stored, and feed the returned flags back on the next operation.

Add and subtract run in plain binary when the decimal flag is clear. When the decimal flag is set they treat each byte as two packed BCD digits. Carry acts as a not-borrow flag for subtraction and compare. Shifts, rotates, increment and decrement act on the operand byte; the caller routes the accumulator there for accumulator-form instructions. Compare and bit-test produce flags only, and return the accumulator unchanged as the result.

The flag byte is laid out with N in bit 7, V in bit 6, a constant 1 in bit 5, B in bit 4, D in bit 3, I in bit 2, Z in bit 1 and C in bit 0.

Top module: `acc_alu`

## Requirements
- R1: While rst_ni is low, result_o is 0x00 and flags_o is 0x20.
- R2: Outputs are registered. A new input set appears on result_o/flags_o after the next rising clock edge, and not before it.
- R3: Code 0 (add), with flag bit 3 (D) clear: result = acc + opnd + C mod 256, and C = bit 8 of the sum. V (bit 6) is set when the two inputs have the same sign and the result sign differs from the accumulator sign.
- R4: Code 1 (subtract), with D clear: result = acc + (opnd XOR 0xFF) + C mod 256, and C = bit 8 of that sum. V uses the same sign rule, applied to the complemented operand.
- R5: Code 0 with D set and both bytes valid BCD: the result is the decimal sum of acc, opnd and C, modulo 100, in packed BCD (for example 0x43 + 0x28 with C clear gives 0x71). C is set when the decimal sum exceeds 99. V is unchanged.
- R6: Code 1 with D set and both bytes valid BCD: the result is acc − opnd − (1 − C) in decimal. A negative result has 100 added and clears C; otherwise C is set. V is unchanged.
- R7: Code 2 (compare): C is set when acc ≥ opnd (unsigned). N and Z come from (acc − opnd) mod 256. V is unchanged, and result equals acc.
- R8: Codes 3, 4 and 5 return acc AND opnd, acc OR opnd and acc XOR opnd respectively. C and V are unchanged.
- R9: Code 6 (bit test): N = opnd bit 7, V = opnd bit 6, and Z is set when (acc AND opnd) is zero. C is unchanged and result equals acc.
- R10: Codes 7 (shift left), 8 (shift right), 9 (rotate left) and 10 (rotate right) act on opnd. The bit shifted out goes to C. The vacated bit takes 0 for the shifts and the incoming C for the rotates. V is unchanged.
- R11: Codes 11 and 12 return opnd + 1 and opnd − 1, modulo 256. C and V are unchanged.
- R12: Every result-producing operation (codes 0, 1, 3, 4, 5 and 7 to 12) sets Z (bit 1) when the result is zero and copies result bit 7 into N (bit 7). Bits B, D and I (4, 3, 2) always pass through. Bit 5 of flags_o is always 1.
- R13: Codes 13, 14 and 15 return acc as the result and flags_i with bit 5 forced to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator byte |
| opnd_i | input | 8 | Operand byte |
| flags_i | input | 8 | Incoming flag byte (N V 1 B D I Z C) |
| result_o | output | 8 | Registered result byte |
| flags_o | output | 8 | Registered updated flag byte |

## Verification
The bench sweeps every accumulator value against a strided set of operands for binary add, subtract and compare. It sweeps every valid BCD accumulator against a strided set of BCD operands for decimal add and subtract, with carry-in both clear and set. These sweeps catch an overflow rule taken from the wrong sign, a decimal digit that fails to wrap past 9 or to borrow below 0, and a carry that reads as borrow instead of not-borrow. Such a design would report the wrong C at 99+1 or 00−1, or a wrong V at 0x7F+1. The logic, bit-test, shift, step and unused codes run with the incoming flag byte varied per vector. This exposes a rotate that ignores the incoming carry, a shift that disturbs V, or a bit-test that takes N from the AND instead of from the operand.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_AND = 4'd3,
    OP_ORA = 4'd4,
    OP_XOR = 4'd5,
    OP_BIT = 4'd6,
    OP_SHL = 4'd7,
    OP_SHR = 4'd8,
    OP_ROL = 4'd9,
    OP_ROR = 4'd10,
    OP_INC = 4'd11,
    OP_DEC = 4'd12
  } alu_op_e;

  localparam int FL_C   = 0;
  localparam int FL_Z   = 1;
  localparam int FL_I   = 2;
  localparam int FL_D   = 3;
  localparam int FL_B   = 4;
  localparam int FL_ONE = 5;
  localparam int FL_V   = 6;
  localparam int FL_N   = 7;
  localparam int FLAG_W = 8;
endpackage

// File: rtl/acc_alu_bin.sv
`timescale 1ns/1ps
module acc_alu_bin #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   tot;

  assign b_eff  = sub_i ? ~b_i : b_i;
  assign tot    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
  assign sum_o  = tot[W-1:0];
  assign cout_o = tot[W];
  assign ovf_o  = ~(a_i[W-1] ^ b_eff[W-1]) & (a_i[W-1] ^ tot[W-1]);
endmodule

// File: rtl/acc_alu_bcd_digit.sv
`timescale 1ns/1ps
module acc_alu_bcd_digit (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       cin_i,   // carry for add, not-borrow for subtract
  input  logic       sub_i,
  output logic [3:0] d_o,
  output logic       cout_o
);
  logic [5:0] raw;

  always_comb begin
    if (sub_i) begin
      raw = {2'b00, a_i} - {2'b00, b_i} - {5'b0, ~cin_i};
      if (raw[5]) begin
        d_o    = 4'(raw + 6'd10);
        cout_o = 1'b0;
      end else begin
        d_o    = raw[3:0];
        cout_o = 1'b1;
      end
    end else begin
      raw = {2'b00, a_i} + {2'b00, b_i} + {5'b0, cin_i};
      if (raw >= 6'd10) begin
        d_o    = 4'(raw - 6'd10);
        cout_o = 1'b1;
      end else begin
        d_o    = raw[3:0];
        cout_o = 1'b0;
      end
    end
  end

  // R5/R6: valid digits in always give a valid digit out
  always_comb begin
    if (a_i <= 4'd9 && b_i <= 4'd9) begin
      a_r5_digit_range: assert (d_o <= 4'd9);
    end
  end
endmodule

// File: rtl/acc_alu_bcd.sv
`timescale 1ns/1ps
module acc_alu_bcd #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  localparam int DIG = W / 4;

  logic [DIG:0] cy;
  assign cy[0] = cin_i;

  for (genvar g = 0; g < DIG; g++) begin : g_dig
    acc_alu_bcd_digit u_dig (
      .a_i   (a_i[4*g +: 4]),
      .b_i   (b_i[4*g +: 4]),
      .cin_i (cy[g]),
      .sub_i (sub_i),
      .d_o   (res_o[4*g +: 4]),
      .cout_o(cy[g+1])
    );
  end

  assign cout_o = cy[DIG];
endmodule

// File: rtl/acc_alu_shift.sv
`timescale 1ns/1ps
module acc_alu_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] val_i,
  input  logic         cin_i,
  input  logic         left_i,
  input  logic         rot_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  logic fill;
  assign fill = rot_i & cin_i;

  always_comb begin
    if (left_i) begin
      res_o  = {val_i[W-2:0], fill};
      cout_o = val_i[W-1];
    end else begin
      res_o  = {fill, val_i[W-1:1]};
      cout_o = val_i[0];
    end
  end
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam logic [DATA_W-1:0] ONE_W = DATA_W'(1);

  logic              cin, dec_mode;
  logic              bin_sub, bin_cin, bin_c, bin_v;
  logic [DATA_W-1:0] bin_sum;
  logic              bcd_c;
  logic [DATA_W-1:0] bcd_res;
  logic              sh_left, sh_rot, sh_c;
  logic [DATA_W-1:0] sh_res;
  logic [DATA_W-1:0] res_d, nz_src;
  logic [FLAG_W-1:0] fl_d;
  logic              set_nz;
  logic [3:0]        op_q;

  assign cin      = flags_i[FL_C];
  assign dec_mode = flags_i[FL_D];
  assign bin_sub  = (op_i == OP_SUB) || (op_i == OP_CMP);
  assign bin_cin  = (op_i == OP_CMP) ? 1'b1 : cin;
  assign sh_left  = (op_i == OP_SHL) || (op_i == OP_ROL);
  assign sh_rot   = (op_i == OP_ROL) || (op_i == OP_ROR);

  acc_alu_bin #(.W(DATA_W)) u_bin (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cin_i (bin_cin),
    .sub_i (bin_sub),
    .sum_o (bin_sum),
    .cout_o(bin_c),
    .ovf_o (bin_v)
  );

  acc_alu_bcd #(.W(DATA_W)) u_bcd (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cin_i (cin),
    .sub_i (op_i == OP_SUB),
    .res_o (bcd_res),
    .cout_o(bcd_c)
  );

  acc_alu_shift #(.W(DATA_W)) u_shift (
    .val_i (opnd_i),
    .cin_i (cin),
    .left_i(sh_left),
    .rot_i (sh_rot),
    .res_o (sh_res),
    .cout_o(sh_c)
  );

  always_comb begin
    res_d  = acc_i;
    fl_d   = flags_i;
    set_nz = 1'b0;
    nz_src = '0;
    case (op_i)
      OP_ADD, OP_SUB: begin
        set_nz = 1'b1;
        if (dec_mode) begin
          res_d      = bcd_res;
          fl_d[FL_C] = bcd_c;
        end else begin
          res_d      = bin_sum;
          fl_d[FL_C] = bin_c;
          fl_d[FL_V] = bin_v;
        end
        nz_src = res_d;
      end
      OP_CMP: begin
        set_nz     = 1'b1;
        fl_d[FL_C] = bin_c;
        nz_src     = bin_sum;
      end
      OP_AND: begin res_d = acc_i & opnd_i; set_nz = 1'b1; nz_src = res_d; end
      OP_ORA: begin res_d = acc_i | opnd_i; set_nz = 1'b1; nz_src = res_d; end
      OP_XOR: begin res_d = acc_i ^ opnd_i; set_nz = 1'b1; nz_src = res_d; end
      OP_BIT: begin
        fl_d[FL_N] = opnd_i[DATA_W-1];
        fl_d[FL_V] = opnd_i[DATA_W-2];
        fl_d[FL_Z] = ((acc_i & opnd_i) == '0);
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        res_d      = sh_res;
        fl_d[FL_C] = sh_c;
        set_nz     = 1'b1;
        nz_src     = sh_res;
      end
      OP_INC: begin res_d = opnd_i + ONE_W; set_nz = 1'b1; nz_src = res_d; end
      OP_DEC: begin res_d = opnd_i - ONE_W; set_nz = 1'b1; nz_src = res_d; end
      default: ;
    endcase
    if (set_nz) begin
      fl_d[FL_N] = nz_src[DATA_W-1];
      fl_d[FL_Z] = (nz_src == '0);
    end
    fl_d[FL_ONE] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      flags_o  <= FLAG_W'(8'h20);
      op_q     <= 4'hF;
    end else begin
      result_o <= res_d;
      flags_o  <= fl_d;
      op_q     <= op_i;
    end
  end

  a_r7_cmp_keeps_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP) |=> (result_o == $past(acc_i)));

  a_r8_logic_keeps_cv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_AND || op_i == OP_ORA || op_i == OP_XOR) |=>
      (flags_o[FL_C] == $past(flags_i[FL_C]) && flags_o[FL_V] == $past(flags_i[FL_V])));

  a_r11_step_keeps_cv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_INC || op_i == OP_DEC) |=>
      (flags_o[FL_C] == $past(flags_i[FL_C]) && flags_o[FL_V] == $past(flags_i[FL_V])));

  a_r12_bdi_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (flags_o[FL_B:FL_I] == $past(flags_i[FL_B:FL_I])));

  a_r12_nz_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q != OP_CMP && op_q != OP_BIT && op_q <= OP_DEC) |->
      (flags_o[FL_Z] == (result_o == '0) && flags_o[FL_N] == result_o[DATA_W-1]));

  a_r13_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > OP_DEC) |=>
      (result_o == $past(acc_i) && flags_o == ($past(flags_i) | FLAG_W'(8'h20))));
endmodule

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] acc = 8'd0, opnd = 8'd0, flg = 8'd0;
  logic [7:0] res, flo;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  acc_alu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .acc_i(acc),
    .opnd_i(opnd), .flags_i(flg), .result_o(res), .flags_o(flo)
  );

  function automatic int bcd2i(input int b);
    return (b / 16) * 10 + (b % 16);
  endfunction

  function automatic int i2bcd(input int v);
    return (v / 10) * 16 + (v % 10);
  endfunction

  function automatic int sgn(input int b);
    return (b >= 128) ? b - 256 : b;
  endfunction

  function automatic string req_of(input int o, input int d);
    case (o)
      0: return d ? "R5" : "R3";
      1: return d ? "R6" : "R4";
      2: return "R7";
      3, 4, 5: return "R8";
      6: return "R9";
      7, 8, 9, 10: return "R10";
      11, 12: return "R11";
      default: return "R13";
    endcase
  endfunction

  // expected {result, flags} from the requirements
  function automatic logic [15:0] model(input int o, input int a, input int m, input int f);
    int r, nzv, s, c, d;
    logic [7:0] fo;
    bit nz;
    fo = f[7:0]; c = f & 1; d = (f >> 3) & 1;
    r = a; nz = 1'b1; nzv = 0;
    case (o)
      0: if (d != 0) begin
           s = bcd2i(a) + bcd2i(m) + c;
           fo[0] = (s > 99); r = i2bcd(s % 100);
         end else begin
           s = a + m + c; r = s & 255; fo[0] = (s > 255);
           s = sgn(a) + sgn(m) + c; fo[6] = (s > 127 || s < -128);
         end
      1: if (d != 0) begin
           s = bcd2i(a) - bcd2i(m) - (1 - c);
           if (s < 0) begin s = s + 100; fo[0] = 1'b0; end else fo[0] = 1'b1;
           r = i2bcd(s);
         end else begin
           s = a + (255 - m) + c; r = s & 255; fo[0] = (s > 255);
           s = sgn(a) - sgn(m) - (1 - c); fo[6] = (s > 127 || s < -128);
         end
      2: begin fo[0] = (a >= m); nzv = (a - m) & 255; end
      3: r = a & m;
      4: r = a | m;
      5: r = a ^ m;
      6: begin nz = 1'b0; fo[7] = m[7]; fo[6] = m[6]; fo[1] = ((a & m) == 0); end
      7: begin r = (m << 1) & 255; fo[0] = m[7]; end
      8: begin r = m >> 1; fo[0] = m[0]; end
      9: begin r = ((m << 1) & 255) | c; fo[0] = m[7]; end
      10: begin r = (m >> 1) | (c << 7); fo[0] = m[0]; end
      11: r = (m + 1) & 255;
      12: r = (m + 255) & 255;
      default: nz = 1'b0;
    endcase
    if (nz) begin
      if (o != 2) nzv = r;
      fo[7] = (nzv >= 128); fo[1] = (nzv == 0);
    end
    fo[5] = 1'b1;
    return {r[7:0], fo};
  endfunction

  task automatic report(input string rq, input logic [15:0] got, input logic [15:0] exp_v);
    checks++;
    if (got !== exp_v) begin
      fails++;
      if (fails <= 20)
        $display("FAIL %s: actual res=%02h flags=%02h expected res=%02h flags=%02h",
                 rq, got[15:8], got[7:0], exp_v[15:8], exp_v[7:0]);
    end
  endtask

  // called at a falling edge; checks one clock later at the next falling edge
  task automatic run(input int o, input int a, input int m, input int f);
    op = 4'(o); acc = 8'(a); opnd = 8'(m); flg = 8'(f);
    @(negedge clk);
    report(req_of(o, (f >> 3) & 1), {res, flo}, model(o, a, m, f));
  endtask

  function automatic int pat(input int o, input int a, input int m);
    return (a * 7 + m * 13 + o * 29) & 255;
  endfunction

  initial begin
    // R1: reset holds outputs while inputs toggle
    op = 4'd0; acc = 8'h55; opnd = 8'h66; flg = 8'hFF;
    repeat (3) @(negedge clk);
    report("R1", {res, flo}, 16'h0020);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: output must not change before the next rising edge
    op = 4'd3; acc = 8'hF0; opnd = 8'h3C; flg = 8'h20;
    @(negedge clk);
    op = 4'd5; acc = 8'hAA; opnd = 8'hFF; flg = 8'h21;
    #1;
    report("R2", {res, flo}, model(3, 8'hF0, 8'h3C, 8'h20));
    @(negedge clk);
    report("R2", {res, flo}, model(5, 8'hAA, 8'hFF, 8'h21));

    // spot cases: R5 example, R6 borrow below zero, R3 signed overflow
    run(0, 8'h43, 8'h28, 8'h28);
    run(0, 8'h99, 8'h00, 8'h29);
    run(1, 8'h00, 8'h00, 8'h28);
    run(0, 8'h7F, 8'h01, 8'h20);
    run(1, 8'h80, 8'h01, 8'h21);

    // R3/R4 binary add/subtract sweep
    for (int o = 0; o < 2; o++)
      for (int a = 0; a < 256; a++)
        for (int mi = 0; mi < 52; mi++)
          for (int c = 0; c < 2; c++)
            run(o, a, mi * 5, (pat(o, a, mi * 5) & 8'hF6) | c);

    // R5/R6 decimal sweep over valid BCD
    for (int o = 0; o < 2; o++)
      for (int ad = 0; ad < 100; ad++)
        for (int md = 0; md < 100; md += 3)
          for (int c = 0; c < 2; c++)
            run(o, i2bcd(ad), i2bcd(md), (pat(o, ad, md) & 8'hF6) | 8'h08 | c);

    // R7 compare sweep
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m += 3)
        run(2, a, m, pat(2, a, m));
    run(2, 8'h40, 8'h40, 8'h00);

    // R8..R13: logic, bit test, shifts, steps, unused codes
    for (int o = 3; o < 16; o++)
      for (int ai = 0; ai < 16; ai++)
        for (int m = 0; m < 256; m++)
          run(o, (ai * 17) & 255, m, pat(o, ai, m));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule